// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock line SCL, data line SDA). A host reaches a byte-wide register file, held outside the block, through an internal pointer register. Both bus lines are sampled by a fast system clock through synchronisers. The block finds START and STOP conditions from those samples. It takes in an address byte and answers only when the upper seven bits equal its own device address.

The device address has a fixed upper part, 01011. The two low bits come from a three-level strap input. That input is decoded while reset is held and then kept until the next reset.

A write transfer has one or two data bytes. The first byte always loads the pointer. The second byte, if sent, is written to the register the pointer selects. A read transfer returns one byte from the register the pointer selects. The pointer keeps its value from one transfer to the next. This lets a pointer-only write followed by a repeated START in the read direction fetch any register.

Top module: `ptr_serial_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a new address phase from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle and discards any byte that is only partly received.
- R2: After a START, eight bits are taken in MSB first on SCL rising edges. They are a 7-bit device address and then a direction bit, where 0 means the host writes and 1 means the host reads.
- R3: When the address does not match, the block does not drive SDA for the ninth clock. It also does not acknowledge, write or drive data for any later byte until the next START.
- R4: The SDA drive-low enable turns on only while the synchronised SCL is low.
- R5: The device address is {01011, L}. The strap code sets L as follows: strap_i = 2'b00 (tied low) gives L = 10, 2'b01 (open) gives L = 00, 2'b10 (tied high) gives L = 01, and 2'b11 is treated as open, giving L = 00.
- R6: The strap is sampled only while rst is high. A change on strap_i after reset is released has no effect on the address.
- R7: In a write transfer, the first data byte loads the pointer and the second is written to the register at the pointer. Both bytes are acknowledged. Any further byte is neither acknowledged nor written.
- R8: In a read transfer, after the address acknowledge the block drives the byte at the pointer, MSB first, changing it on SCL falling edges. It then releases SDA for the host's acknowledge bit and drives nothing more until the next START, whether the host sends ACK or NACK.
- R9: The pointer keeps its value across STOP and repeated START and never increments on its own.
- R10: reg_addr_o always shows the pointer. reg_we_o is a pulse one clock long, with reg_wdata_o valid in the same cycle. reg_rdata_i is taken one clock after the address it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| strap_i | input | 2 | Three-level strap code: 00 tied low, 01 open, 10 tied high |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr_o | output | 8 | Register file address (the pointer) |
| reg_we_o | output | 1 | Register file write strobe |
| reg_wdata_o | output | 8 | Register file write data |
| reg_rdata_i | input | 8 | Register file read data, one clock after the address |

## Verification
Two events can land in the same sampling window. The first is a pointer load made in one transfer. The second is the read fetch that a repeated START sets up soon after, together with the SCL rise of that repeated START, which the block takes in as a data bit before the START overrides it. The bench sends pointer-only writes followed directly by read transfers for every strap setting. It also breaks off address and data bytes partway with a START or STOP. Each returned byte is compared with a register model kept in the bench, so a stale pointer, a wrongly shifted bit or a missed override shows up as a wrong byte or a wrong acknowledge.

// File: rtl/ptrs_pkg.sv
`timescale 1ns/1ps
package ptrs_pkg;

    localparam int BYTE_W  = 8;
    localparam int DEV_W   = BYTE_W - 1;
    localparam int STRAP_W = 2;
    localparam int LOW_W   = 2;
    localparam int HI_W    = DEV_W - LOW_W;

    typedef enum logic [STRAP_W-1:0] {
        STRAP_GND  = 2'b00,
        STRAP_OPEN = 2'b01,
        STRAP_VCC  = 2'b10,
        STRAP_BAD  = 2'b11
    } strap_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } xfer_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [LOW_W-1:0] strap_low_bits(input logic [STRAP_W-1:0] code);
        logic [LOW_W-1:0] r;
        case (code)
            STRAP_GND: r = 2'b10;
            STRAP_VCC: r = 2'b01;
            default:   r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ptrs_bus_sync.sv
`timescale 1ns/1ps
module ptrs_bus_sync
    import ptrs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             scl_q;
    logic             sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar gl = 0; gl < LINES; gl++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[gl]};
            end
        end
        assign synced[gl] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[1];
            sda_q <= synced[0];
        end
    end

    always_comb begin
        evt.scl      = synced[1];
        evt.sda      = synced[0];
        evt.scl_rise = synced[1] && !scl_q;
        evt.scl_fall = !synced[1] && scl_q;
        evt.start    = synced[1] && scl_q && sda_q && !synced[0];
        evt.stop     = synced[1] && scl_q && !sda_q && synced[0];
    end

endmodule

// File: rtl/ptrs_strap_latch.sv
`timescale 1ns/1ps
module ptrs_strap_latch
    import ptrs_pkg::*;
#(
    parameter logic [HI_W-1:0] DEV_HI = 5'b01011
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [DEV_W-1:0]   dev_addr
);
    logic [LOW_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= strap_low_bits(strap_i);
        end
    end

    assign dev_addr = {DEV_HI, low_q};

endmodule

// File: rtl/ptrs_xfer_fsm.sv
`timescale 1ns/1ps
module ptrs_xfer_fsm
    import ptrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] rdata,
    output logic              drive_low,
    output logic [BYTE_W-1:0] ptr,
    output logic              we,
    output logic [BYTE_W-1:0] wdata,
    output xfer_state_e       state
);
    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              ack_on;
    logic              rw;
    logic [BYTE_W-1:0] rx_byte;

    assign rx_byte = {sh[BYTE_W-2:0], evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            ack_on    <= 1'b0;
            rw        <= 1'b0;
            drive_low <= 1'b0;
            ptr       <= '0;
            we        <= 1'b0;
            wdata     <= '0;
        end else begin
            we <= 1'b0;
            if (evt.start) begin
                state     <= ST_ADDR;
                cnt       <= '0;
                ack_on    <= 1'b0;
                drive_low <= 1'b0;
            end else if (evt.stop) begin
                state     <= ST_IDLE;
                ack_on    <= 1'b0;
                drive_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (evt.scl_rise) begin
                            sh  <= rx_byte;
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                case (state)
                                    ST_ADDR: begin
                                        if (rx_byte[BYTE_W-1:1] == dev_addr) begin
                                            rw    <= rx_byte[0];
                                            state <= ST_ADDR_ACK;
                                        end else begin
                                            state <= ST_IGNORE;
                                        end
                                    end
                                    ST_PTR: begin
                                        ptr   <= rx_byte;
                                        state <= ST_PTR_ACK;
                                    end
                                    default: begin
                                        we    <= 1'b1;
                                        wdata <= rx_byte;
                                        state <= ST_DATA_ACK;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_DATA_ACK: begin
                        if (evt.scl_fall) begin
                            if (!ack_on) begin
                                ack_on    <= 1'b1;
                                drive_low <= 1'b1;
                            end else begin
                                ack_on    <= 1'b0;
                                drive_low <= 1'b0;
                                cnt       <= '0;
                                case (state)
                                    ST_ADDR_ACK: begin
                                        if (rw) begin
                                            state     <= ST_TX;
                                            sh        <= rdata;
                                            drive_low <= ~rdata[BYTE_W-1];
                                        end else begin
                                            state <= ST_PTR;
                                        end
                                    end
                                    ST_PTR_ACK: state <= ST_DATA;
                                    default:    state <= ST_IGNORE;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                drive_low <= 1'b0;
                                state     <= ST_TX_ACK;
                            end else begin
                                sh        <= {sh[BYTE_W-2:0], 1'b0};
                                drive_low <= ~sh[BYTE_W-2];
                                cnt       <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            state <= ST_IGNORE;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ptr_serial_slave.sv
`timescale 1ns/1ps
module ptr_serial_slave
    import ptrs_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [HI_W-1:0]  DEV_HI      = 5'b01011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic              reg_we_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    bus_evt_t          evt;
    logic [DEV_W-1:0]  dev_addr;
    xfer_state_e       state;

    ptrs_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    ptrs_strap_latch #(
        .DEV_HI (DEV_HI)
    ) u_strap (
        .clk      (clk),
        .rst      (rst),
        .strap_i  (strap_i),
        .dev_addr (dev_addr)
    );

    ptrs_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .dev_addr  (dev_addr),
        .rdata     (reg_rdata_i),
        .drive_low (sda_drive_low_o),
        .ptr       (reg_addr_o),
        .we        (reg_we_o),
        .wdata     (reg_wdata_o),
        .state     (state)
    );

endmodule

// File: rtl/ptr_serial_slave_checker.sv
`timescale 1ns/1ps
module ptr_serial_slave_checker
    import ptrs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              drive,
    input logic              scl_s,
    input logic              scl_rise,
    input logic              we,
    input logic [BYTE_W-1:0] ptr,
    input logic [DEV_W-1:0]  dev_addr,
    input xfer_state_e       st
);
    p_drive_on_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> !$past(scl_s));

    p_strap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(dev_addr));

    p_we_single_r10: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

    p_quiet_when_unaddressed_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE || st == ST_IDLE) |-> !drive);

    p_ptr_on_scl_rise_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr) |-> $past(scl_rise));

endmodule

bind ptr_serial_slave ptr_serial_slave_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .drive    (sda_drive_low_o),
    .scl_s    (evt.scl),
    .scl_rise (evt.scl_rise),
    .we       (reg_we_o),
    .ptr      (reg_addr_o),
    .dev_addr (dev_addr),
    .st       (state)
);

// File: tb/ptr_serial_slave_bench.sv
`timescale 1ns/1ps
module ptr_serial_slave_bench;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       drv;
    logic       sda_bus;
    logic [7:0] addr_w;
    logic [7:0] wdata_w;
    logic [7:0] rdata_r;
    logic       we_w;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic       mem_ready = 1'b0;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~drv;

    ptr_serial_slave u_ptr_serial_slave (
        .clk             (clk),
        .rst             (rst),
        .strap_i         (strap),
        .scl_i           (scl_m),
        .sda_i           (sda_bus),
        .sda_drive_low_o (drv),
        .reg_addr_o      (addr_w),
        .reg_we_o        (we_w),
        .reg_wdata_o     (wdata_w),
        .reg_rdata_i     (rdata_r)
    );

    always @(posedge clk) begin
        if (!mem_ready) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
            mem_ready <= 1'b1;
        end else if (we_w) begin
            mem[addr_w] <= wdata_w;
        end
        rdata_r <= mem[addr_w];
    end

    function automatic logic [6:0] own_addr(input logic [1:0] s);
        logic [1:0] low;
        low = (s == 2'd0) ? 2'b10 : (s == 2'd2) ? 2'b01 : 2'b00;
        return {5'b01011, low};
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        acked = ~sda_bus; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(1);
            scl_m = 1'b1; wq(1);
            b[i] = sda_bus; wq(1);
            scl_m = 1'b0; wq(1);
        end
        sda_m = ~host_ack; wq(1);
        scl_m = 1'b1;      wq(2);
        scl_m = 1'b0;      wq(1);
    endtask

    task automatic write_reg(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] v,
                             output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        put_byte({dev, 1'b0}, a0);
        put_byte(p, a1);
        put_byte(v, a2);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic read_reg(input logic [6:0] dev, input logic [7:0] p, output logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        put_byte({dev, 1'b0}, a0);
        put_byte(p, a1);
        bus_start();
        put_byte({dev, 1'b1}, a2);
        get_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic read_cur(input logic [6:0] dev, output logic acked, output logic [7:0] d);
        bus_start();
        put_byte({dev, 1'b1}, acked);
        get_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       a0, a1, a2;
        logic [7:0] d;
        logic [6:0] me, cand;
        logic [7:0] p;
        logic [7:0] v;

        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);

        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 reset drive idle", int'(drv), 0);
        chk("R10 reset write strobe idle", int'(we_w), 0);

        // Strap sweep: R5, R6, R3, R8
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            rst = 1'b1;
            repeat (6) @(negedge clk);
            rst = 1'b0;
            strap = 2'(s) ^ 2'b11;
            repeat (4) @(negedge clk);
            me = own_addr(2'(s));

            bus_start();
            put_byte({me, 1'b0}, a0);
            chk("R5 own address acknowledged", int'(a0), 1);
            put_byte(8'(s * 16 + 3), a1);
            chk("R7 pointer byte acknowledged", int'(a1), 1);
            bus_start();
            put_byte({me, 1'b1}, a2);
            chk("R2 read address acknowledged", int'(a2), 1);
            get_byte(1'b0, d);
            bus_stop();
            chk("R8 byte at pointer", int'(d), int'(exp_mem[s * 16 + 3]));

            for (int b = 0; b < 7; b++) begin
                cand = me ^ 7'(1 << b);
                bus_start();
                put_byte({cand, 1'b0}, a0);
                chk("R3 mismatched address not acknowledged", int'(a0), 0);
                put_byte(8'h55, a1);
                chk("R3 byte after mismatch not acknowledged", int'(a1), 0);
                put_byte(8'hA5, a2);
                chk("R3 second byte after mismatch not acknowledged", int'(a2), 0);
                bus_stop();
            end

            cand = own_addr(strap);
            if (cand != me) begin
                bus_start();
                put_byte({cand, 1'b0}, a0);
                chk("R6 strap change after reset ignored", int'(a0), 0);
                bus_stop();
            end

            bus_start();
            put_byte({me ^ 7'h40, 1'b1}, a0);
            chk("R3 mismatched read not acknowledged", int'(a0), 0);
            get_byte(1'b0, d);
            chk("R3 bus released on mismatched read", int'(d), 255);
            bus_stop();

            read_reg(me, 8'h55, d);
            chk("R3 no write when unaddressed", int'(d), int'(exp_mem[8'h55]));
        end

        me = own_addr(2'b11);

        // Write/read sweep: R7, R10
        for (int k = 0; k < 16; k++) begin
            p = 8'(k * 17 + 1);
            v = 8'(k * 29 + 100);
            write_reg(me, p, v, a0);
            chk("R7 write transfer acknowledged", int'(a0), 1);
            exp_mem[p] = v;
            read_reg(me, p, d);
            chk("R10 written value read back", int'(d), int'(v));
        end

        // R9: no increment after write, pointer retained over transfers
        write_reg(me, 8'h90, 8'h3C, a0);
        exp_mem[8'h90] = 8'h3C;
        read_cur(me, a0, d);
        chk("R9 pointer not incremented by write", int'(d), 8'h3C);
        read_cur(me, a0, d);
        chk("R9 pointer retained after read", int'(d), 8'h3C);

        // R7: third byte refused
        bus_start();
        put_byte({me, 1'b0}, a0);
        put_byte(8'h40, a1);
        put_byte(8'h11, a1);
        put_byte(8'h22, a2);
        chk("R7 extra write byte not acknowledged", int'(a2), 0);
        bus_stop();
        exp_mem[8'h40] = 8'h11;
        read_reg(me, 8'h40, d);
        chk("R7 second byte written", int'(d), 8'h11);
        read_reg(me, 8'h41, d);
        chk("R7 extra byte not written", int'(d), int'(exp_mem[8'h41]));

        // R8: host ACK still ends the read after one byte
        bus_start();
        put_byte({me, 1'b1}, a0);
        get_byte(1'b1, d);
        chk("R8 read byte with host ack", int'(d), int'(exp_mem[8'h41]));
        get_byte(1'b0, d);
        chk("R8 single byte per read", int'(d), 255);
        bus_stop();

        // R1: STOP in the middle of a data byte
        bus_start();
        put_byte({me, 1'b0}, a0);
        put_byte(8'h30, a1);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        bus_stop();
        read_cur(me, a0, d);
        chk("R1 stop discards partial byte", int'(d), int'(exp_mem[8'h30]));

        // R1: START in the middle of an address byte
        bus_start();
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        bus_start();
        put_byte({me, 1'b1}, a0);
        chk("R1 restart mid-byte acknowledged", int'(a0), 1);
        get_byte(1'b0, d);
        bus_stop();
        chk("R1 restart read data", int'(d), int'(exp_mem[8'h30]));

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

endmodule